// File: doc/BRIEF.md
# Smart Panel Parallel Bus Sequencer

This block moves pixel and command traffic between a host and a smart display panel over an 8080-style parallel bus. The host pushes byte, halfword or word entries into a transmit queue. The block cuts each entry into 8-bit or 16-bit bus beats. It frames each beat with an active-low write strobe, and holds an active-low chip select for the whole transfer. A command/data line stays fixed for the whole transfer.

Each bus cycle has two parts: an active part, in which the strobe is low, and a recovery part, in which it is high. Both lengths are counted in ticks of a clock enable, which divides the functional clock by 1 to 8. Writes and reads have separate timing fields. A programmed beat count ends the transfer. In read mode the bus is sampled one tick after the read strobe rises, and the samples are packed into 32-bit words in a receive queue. A drained flag tells the host that every queued write has reached the bus.

Top module: `dbus_seq`

## Requirements
- R1: The strobe stays low for (active field + 1) ticks. The write fields `wr_act` and the read fields `rd_act` are separate.
- R2: The strobe stays high between consecutive beats for max(recovery field + 1, 3) ticks. Recovery values 0 and 1 act as 2.
- R3: A tick lasts (`div_sel` + 1) functional clocks, so the divide is 1 to 8.
- R4: A transfer issues exactly `cyc_len` + 1 beats and then stops strobing. Entries that are still queued stay unsent.
- R5: `wide_bus`=0 selects 8-bit beats and 1 selects 16-bit beats. A push with `tx_size`=2 (word) gives 4 or 2 beats. `tx_size`=1 (halfword) gives 2 or 1. `tx_size`=0 (byte) gives 1 beat. Unused upper bits of a byte or halfword push are sent as zero.
- R6: With `reorder_en`=0, lanes go out least significant first, and on reads they fill the word from the least significant end. With `reorder_en`=1 the order is most significant first, in both directions.
- R7: `dc_line` carries the `dc_sel` value captured at the start of the transfer (0 command, 1 data). It stays unchanged while `cs_n` is low.
- R8: A 1-to-0 change on `xfer_stop` starts a transfer and pulls `cs_n` low. `cs_n` stays low after the last beat. Driving `xfer_stop` to 1 raises `cs_n` on the next clock and aborts any beat in progress.
- R9: `wr_drained` is 1 exactly when no pushed entry is waiting or partly sent.
- R10: The transmit path holds 8 queued entries plus one being sent. When it is full, `tx_ready` is 0 and pushes are refused.
- R11: In read mode (`rd_mode`=1), `bus_oe` is 0 and `rd_n` pulses instead of `wr_n`. `bus_din` is sampled one tick after `rd_n` rises. Every 32/width samples form a `rx_data` word. The last beat of the transfer flushes a partial word with zero fill.
- R12: After reset, `cs_n`, `wr_n` and `rd_n` are 1, `dc_line` is 0, `tx_ready` and `wr_drained` are 1, and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Push an entry into the transmit queue |
| tx_size | input | 2 | Push size: 0 byte, 1 halfword, 2 word |
| tx_wdata | input | 32 | Push data, right aligned |
| tx_ready | output | 1 | Transmit queue can accept a push |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 32 | Head of the receive queue |
| rx_valid | output | 1 | Receive queue is not empty |
| xfer_stop | input | 1 | 1-to-0 starts a transfer, 1 ends it |
| rd_mode | input | 1 | Transfer direction: 0 write, 1 read |
| dc_sel | input | 1 | Command (0) or data (1) for the next transfer |
| wide_bus | input | 1 | Beat width: 0 for 8 bits, 1 for 16 bits |
| reorder_en | input | 1 | Most significant lane first |
| cyc_len | input | 18 | Beats in the transfer minus one |
| div_sel | input | 3 | Tick divide minus one |
| wr_act | input | 4 | Write strobe low ticks minus one |
| wr_rec | input | 6 | Write recovery ticks minus one |
| rd_act | input | 4 | Read strobe low ticks minus one |
| rd_rec | input | 6 | Read recovery ticks minus one |
| wr_drained | output | 1 | All pushed data has been sent |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| dc_line | output | 1 | Command/data select |
| bus_dout | output | 16 | Beat driven to the panel |
| bus_din | input | 16 | Beat returned by the panel |
| bus_oe | output | 1 | Bus driven by this block |

## Verification
The hardest case to reach is back-pressure on the transmit path. One entry is pulled out of the queue ahead of time into the beat register, so the queue only fills when the ninth push lands while no transfer runs. The bench makes nine back-to-back pushes with `xfer_stop` held high and checks `tx_ready` after the eighth and after the ninth. It then drains all eighteen beats in one transfer and compares each beat. A second hard case is the read sample point. The bench model puts a value on `bus_din` when `rd_n` falls and overwrites it with junk two clocks after `rd_n` rises. A design that samples late, or packs lanes in the wrong order, therefore returns a wrong word.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } push_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACT,
        ST_REC,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [31:0] data;
        push_size_e  size;
    } tx_entry_t;

    typedef struct packed {
        logic wide;
        logic reorder;
        logic rd;
        logic dc;
    } xfer_cfg_t;

    // Number of bus beats that one queue entry produces.
    function automatic logic [2:0] beats_for(input push_size_e sz, input logic wide);
        case (sz)
            SZ_WORD: return wide ? 3'd2 : 3'd4;
            SZ_HALF: return wide ? 3'd1 : 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // Select one lane of a 32-bit entry as a bus beat.
    function automatic logic [15:0] lane_of(input logic [31:0] d, input logic [1:0] lane,
                                            input logic wide);
        if (wide)
            return lane[0] ? d[31:16] : d[15:0];
        return {8'h00, d[{lane, 3'b000} +: 8]};
    endfunction

    // Zero the bits above the pushed size.
    function automatic logic [31:0] mask_push(input push_size_e sz, input logic [31:0] d);
        case (sz)
            SZ_BYTE: return {24'h0, d[7:0]};
            SZ_HALF: return {16'h0, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dbus_fifo.sv
module dbus_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          do_push;
    logic          do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign dout    = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push)
                wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_pop)
                rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= (AW+1)'(DEPTH));

    a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

endmodule

// File: rtl/dbus_tick.sv
module dbus_tick #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div_sel);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= tick ? '0 : cnt + DIV_W'(1);
    end

endmodule

// File: rtl/dbus_engine.sv
module dbus_engine
    import dbus_pkg::*;
#(
    parameter int LEN_W = 18,
    parameter int ACT_W = 4,
    parameter int REC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             xfer_stop,
    input  xfer_cfg_t        cfg_in,
    input  logic [LEN_W-1:0] len,
    input  logic [ACT_W-1:0] wr_act,
    input  logic [REC_W-1:0] wr_rec,
    input  logic [ACT_W-1:0] rd_act,
    input  logic [REC_W-1:0] rd_rec,
    input  logic             tx_valid,
    input  tx_entry_t        tx_head,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    input  logic [15:0]      bus_din,
    output logic [15:0]      bus_dout,
    output logic             bus_oe,
    output logic             cs_n,
    output logic             wr_n,
    output logic             rd_n,
    output logic             dc,
    output logic             drained
);
    localparam int CNT_W = (ACT_W > REC_W) ? ACT_W : REC_W;

    seq_state_e       state;
    xfer_cfg_t        cfg;
    logic             stop_q;
    logic [LEN_W:0]   left;
    logic [CNT_W-1:0] tcnt;

    logic             cur_valid;
    logic [31:0]      cur_data;
    push_size_e       cur_size;
    logic [2:0]       cur_idx;
    logic [2:0]       cur_nb;
    logic             cur_last;
    logic [2:0]       wlane;

    logic [31:0]      rx_acc;
    logic [31:0]      acc_next;
    logic [1:0]       rx_cnt;
    logic [1:0]       bpw_m1;
    logic [1:0]       pos;

    logic [CNT_W-1:0] act_m1;
    logic [CNT_W-1:0] rec_m1;
    logic             start;
    logic             rec_end;
    logic             sample;
    logic             beat_ready;
    logic             next_ready;
    logic             load;

    // Timing selection, with the recovery floor of three ticks.
    always_comb begin
        if (cfg.rd) begin
            act_m1 = CNT_W'(rd_act);
            rec_m1 = (rd_rec < REC_W'(2)) ? CNT_W'(2) : CNT_W'(rd_rec);
        end else begin
            act_m1 = CNT_W'(wr_act);
            rec_m1 = (wr_rec < REC_W'(2)) ? CNT_W'(2) : CNT_W'(wr_rec);
        end
    end

    assign start    = (state == ST_IDLE) && stop_q && !xfer_stop;
    assign rec_end  = (state == ST_REC) && tick && (tcnt == '0);
    assign sample   = (state == ST_REC) && tick && (tcnt == rec_m1) && cfg.rd;

    assign cur_nb   = beats_for(cur_size, cfg.wide);
    assign cur_last = (cur_idx + 3'd1) >= cur_nb;
    assign wlane    = cfg.reorder ? (cur_nb - 3'd1 - cur_idx) : cur_idx;

    assign beat_ready = cfg.rd ? !rx_full : cur_valid;
    assign next_ready = cfg.rd ? !rx_full : (!cur_last || tx_valid);

    assign load   = tx_valid && (!cur_valid || (rec_end && !cfg.rd && cur_last));
    assign tx_pop = load;

    // Sequencer state
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cfg    <= '0;
            stop_q <= 1'b1;
            left   <= '0;
            tcnt   <= '0;
        end else begin
            stop_q <= xfer_stop;
            if (xfer_stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (stop_q) begin
                        state <= ST_WAIT;
                        cfg   <= cfg_in;
                        left  <= {1'b0, len} + (LEN_W+1)'(1);
                    end
                    ST_WAIT: if (tick && beat_ready) begin
                        state <= ST_ACT;
                        tcnt  <= act_m1;
                    end
                    ST_ACT: if (tick) begin
                        if (tcnt == '0) begin
                            state <= ST_REC;
                            tcnt  <= rec_m1;
                        end else begin
                            tcnt <= tcnt - CNT_W'(1);
                        end
                    end
                    ST_REC: if (tick) begin
                        if (tcnt == '0) begin
                            left <= left - (LEN_W+1)'(1);
                            if (left == (LEN_W+1)'(1)) begin
                                state <= ST_DONE;
                            end else if (next_ready) begin
                                state <= ST_ACT;
                                tcnt  <= act_m1;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else begin
                            tcnt <= tcnt - CNT_W'(1);
                        end
                    end
                    ST_DONE: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Entry being unpacked into beats
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_valid <= 1'b0;
            cur_data  <= '0;
            cur_size  <= SZ_BYTE;
            cur_idx   <= '0;
        end else if (load) begin
            cur_valid <= 1'b1;
            cur_data  <= tx_head.data;
            cur_size  <= tx_head.size;
            cur_idx   <= '0;
        end else if (rec_end && !cfg.rd && cur_valid) begin
            if (cur_last)
                cur_valid <= 1'b0;
            else
                cur_idx <= cur_idx + 3'd1;
        end
    end

    // Read packing
    assign bpw_m1 = cfg.wide ? 2'd1 : 2'd3;
    assign pos    = cfg.reorder ? (bpw_m1 - rx_cnt) : rx_cnt;

    always_comb begin
        acc_next = rx_acc;
        if (cfg.wide)
            acc_next[{pos[0], 4'b0000} +: 16] = bus_din;
        else
            acc_next[{pos, 3'b000} +: 8] = bus_din[7:0];
    end

    assign rx_word = acc_next;
    assign rx_push = sample && ((rx_cnt == bpw_m1) || (left == (LEN_W+1)'(1)));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            rx_acc <= '0;
            rx_cnt <= '0;
        end else if (sample) begin
            if (rx_push) begin
                rx_acc <= '0;
                rx_cnt <= '0;
            end else begin
                rx_acc <= acc_next;
                rx_cnt <= rx_cnt + 2'd1;
            end
        end
    end

    assign cs_n     = (state == ST_IDLE);
    assign wr_n     = !((state == ST_ACT) && !cfg.rd);
    assign rd_n     = !((state == ST_ACT) && cfg.rd);
    assign bus_oe   = !cs_n && !cfg.rd;
    assign dc       = cfg.dc;
    assign bus_dout = lane_of(cur_data, wlane[1:0], cfg.wide);
    assign drained  = !cur_valid && !tx_valid;

    a_r2_rec_floor: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REC && $past(state) == ST_ACT) |-> tcnt >= CNT_W'(2));

    a_r4_left_live: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT || state == ST_ACT || state == ST_REC) |-> left != '0);

    a_r7_dc_stable: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(dc));

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
        xfer_stop |=> cs_n);

    a_r11_rx_space: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

endmodule

// File: rtl/dbus_seq.sv
module dbus_seq
    import dbus_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 18,
    parameter int ACT_W      = 4,
    parameter int REC_W      = 6,
    parameter int DIV_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_push,
    input  logic [1:0]       tx_size,
    input  logic [31:0]      tx_wdata,
    output logic             tx_ready,
    input  logic             rx_pop,
    output logic [31:0]      rx_data,
    output logic             rx_valid,
    input  logic             xfer_stop,
    input  logic             rd_mode,
    input  logic             dc_sel,
    input  logic             wide_bus,
    input  logic             reorder_en,
    input  logic [LEN_W-1:0] cyc_len,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [ACT_W-1:0] wr_act,
    input  logic [REC_W-1:0] wr_rec,
    input  logic [ACT_W-1:0] rd_act,
    input  logic [REC_W-1:0] rd_rec,
    output logic             wr_drained,
    output logic             cs_n,
    output logic             wr_n,
    output logic             rd_n,
    output logic             dc_line,
    output logic [15:0]      bus_dout,
    input  logic [15:0]      bus_din,
    output logic             bus_oe
);
    localparam int ENTRY_W = $bits(tx_entry_t);

    tx_entry_t push_entry;
    tx_entry_t head_entry;
    xfer_cfg_t cfg_in;
    logic      tx_full;
    logic      tx_empty;
    logic      tx_pop;
    logic      rx_full;
    logic      rx_empty;
    logic      rx_push;
    logic [31:0] rx_word;
    logic      tick;

    assign push_entry.size = push_size_e'(tx_size);
    assign push_entry.data = mask_push(push_size_e'(tx_size), tx_wdata);
    assign tx_ready        = !tx_full;
    assign rx_valid        = !rx_empty;

    assign cfg_in.wide    = wide_bus;
    assign cfg_in.reorder = reorder_en;
    assign cfg_in.rd      = rd_mode;
    assign cfg_in.dc      = dc_sel;

    dbus_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) tx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (push_entry),
        .full  (tx_full),
        .pop   (tx_pop),
        .dout  (head_entry),
        .empty (tx_empty)
    );

    dbus_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) rx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rx_word),
        .full  (rx_full),
        .pop   (rx_pop),
        .dout  (rx_data),
        .empty (rx_empty)
    );

    dbus_tick #(.DIV_W(DIV_W)) tick_gen (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    dbus_engine #(.LEN_W(LEN_W), .ACT_W(ACT_W), .REC_W(REC_W)) engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .xfer_stop (xfer_stop),
        .cfg_in    (cfg_in),
        .len       (cyc_len),
        .wr_act    (wr_act),
        .wr_rec    (wr_rec),
        .rd_act    (rd_act),
        .rd_rec    (rd_rec),
        .tx_valid  (!tx_empty),
        .tx_head   (head_entry),
        .tx_pop    (tx_pop),
        .rx_full   (rx_full),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .bus_din   (bus_din),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .dc        (dc_line),
        .drained   (wr_drained)
    );

endmodule

// File: tb/dbus_seq_tb.sv
module dbus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_push = 1'b0;
    logic [1:0]  tx_size = 2'd2;
    logic [31:0] tx_wdata = '0;
    logic        tx_ready;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        xfer_stop = 1'b1;
    logic        rd_mode = 1'b0;
    logic        dc_sel = 1'b1;
    logic        wide_bus = 1'b0;
    logic        reorder_en = 1'b0;
    logic [17:0] cyc_len = '0;
    logic [2:0]  div_sel = '0;
    logic [3:0]  wr_act = '0;
    logic [5:0]  wr_rec = '0;
    logic [3:0]  rd_act = '0;
    logic [5:0]  rd_rec = '0;
    logic        wr_drained;
    logic        cs_n;
    logic        wr_n;
    logic        rd_n;
    logic        dc_line;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_oe;

    int errors = 0;
    int checks = 0;

    // bus monitor state
    logic [15:0] beat_d [0:63];
    int          gap [0:63];
    int          nb = 0;
    int          lo_cnt = 0;
    int          hi_cnt = 0;
    int          last_lo = 0;
    logic        prev_wr = 1'b1;
    logic        prev_rd = 1'b1;
    logic [15:0] rd_vals [0:7];
    int          rd_i = 0;
    int          rd_lo = 0;
    int          rd_w = 0;
    int          junk = 0;

    always #5 clk = ~clk;

    dbus_seq dut_i (
        .clk(clk), .rst(rst), .tx_push(tx_push), .tx_size(tx_size), .tx_wdata(tx_wdata),
        .tx_ready(tx_ready), .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .xfer_stop(xfer_stop), .rd_mode(rd_mode), .dc_sel(dc_sel), .wide_bus(wide_bus),
        .reorder_en(reorder_en), .cyc_len(cyc_len), .div_sel(div_sel), .wr_act(wr_act),
        .wr_rec(wr_rec), .rd_act(rd_act), .rd_rec(rd_rec), .wr_drained(wr_drained),
        .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .dc_line(dc_line), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_oe(bus_oe)
    );

    // Panel model: records write beats and serves read beats.
    always @(negedge clk) begin
        if (prev_wr && !wr_n) begin
            if (nb < 64) begin
                beat_d[nb] = bus_dout;
                gap[nb]    = hi_cnt;
            end
            nb     = nb + 1;
            lo_cnt = 1;
        end else if (!wr_n) begin
            lo_cnt = lo_cnt + 1;
        end
        if (!prev_wr && wr_n) begin
            last_lo = lo_cnt;
            hi_cnt  = 1;
        end else if (wr_n) begin
            hi_cnt = hi_cnt + 1;
        end
        prev_wr = wr_n;

        if (prev_rd && !rd_n) begin
            bus_din = rd_vals[rd_i[2:0]];
            rd_i    = rd_i + 1;
            rd_lo   = 1;
        end else if (!rd_n) begin
            rd_lo = rd_lo + 1;
        end
        if (!prev_rd && rd_n) begin
            rd_w = rd_lo;
            junk = 2;
        end else if (junk > 0) begin
            junk = junk - 1;
            if (junk == 0)
                bus_din = 16'hDEAD;
        end
        prev_rd = rd_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] sz, input logic [31:0] d);
        while (!tx_ready) @(negedge clk);
        tx_push  = 1'b1;
        tx_size  = sz;
        tx_wdata = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic begin_xfer;
        nb   = 0;
        rd_i = 0;
        @(negedge clk);
        xfer_stop = 1'b0;
    endtask

    task automatic end_xfer;
        xfer_stop = 1'b1;
        @(negedge clk);
        chk("R8 cs_n released", {31'h0, cs_n}, 32'h1);
    endtask

    task automatic wait_beats(input int n);
        for (int k = 0; k < 4000 && nb < n; k++) @(negedge clk);
        repeat (100) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R12 cs_n", {31'h0, cs_n}, 32'h1);
        chk("R12 wr_n", {31'h0, wr_n}, 32'h1);
        chk("R12 rd_n", {31'h0, rd_n}, 32'h1);
        chk("R12 dc_line", {31'h0, dc_line}, 32'h0);
        chk("R12 tx_ready", {31'h0, tx_ready}, 32'h1);
        chk("R12 drained", {31'h0, wr_drained}, 32'h1);
        chk("R12 rx_valid", {31'h0, rx_valid}, 32'h0);
    endtask

    // 16-bit words, divide 1, active 3 ticks, recovery 5 ticks, data
    task automatic t_wide_write;
        wide_bus = 1; reorder_en = 0; div_sel = 0; wr_act = 2; wr_rec = 4;
        dc_sel = 1; rd_mode = 0; cyc_len = 3;
        push(2'd2, 32'h1111_2222);
        push(2'd2, 32'h3333_4444);
        chk("R9 drained low while queued", {31'h0, wr_drained}, 32'h0);
        begin_xfer();
        @(negedge clk);
        chk("R8 cs_n low after start", {31'h0, cs_n}, 32'h0);
        wait_beats(4);
        chk("R4 beat count", nb, 4);
        chk("R5 R6 beat0", beat_d[0], 32'h2222);
        chk("R5 R6 beat1", beat_d[1], 32'h1111);
        chk("R5 R6 beat2", beat_d[2], 32'h4444);
        chk("R5 R6 beat3", beat_d[3], 32'h3333);
        chk("R1 low width", last_lo, 3);
        chk("R2 recovery", gap[2], 5);
        chk("R7 dc data", {31'h0, dc_line}, 32'h1);
        chk("R8 cs_n held after last beat", {31'h0, cs_n}, 32'h0);
        chk("R9 drained", {31'h0, wr_drained}, 32'h1);
        chk("R11 bus_oe on write", {31'h0, bus_oe}, 32'h1);
        end_xfer();
    endtask

    // 8-bit reordered, divide 3, recovery floor, command
    task automatic t_narrow_reorder;
        wide_bus = 0; reorder_en = 1; div_sel = 2; wr_act = 0; wr_rec = 0;
        dc_sel = 0; cyc_len = 3;
        push(2'd2, 32'hA1B2_C3D4);
        begin_xfer();
        wait_beats(4);
        chk("R4 beat count", nb, 4);
        chk("R6 reorder beat0", beat_d[0], 32'h00A1);
        chk("R6 reorder beat1", beat_d[1], 32'h00B2);
        chk("R6 reorder beat3", beat_d[3], 32'h00D4);
        chk("R3 R1 low width div3", last_lo, 3);
        chk("R2 R3 recovery floor", gap[1], 9);
        chk("R7 dc command", {31'h0, dc_line}, 32'h0);
        end_xfer();
    endtask

    // byte and halfword pushes in both widths
    task automatic t_mixed_sizes;
        wide_bus = 0; reorder_en = 0; div_sel = 0; wr_act = 1; wr_rec = 2; dc_sel = 1;
        cyc_len = 2;
        push(2'd0, 32'hFFFF_FF5A);
        push(2'd1, 32'hEEEE_1234);
        begin_xfer();
        wait_beats(3);
        chk("R5 byte beat", beat_d[0], 32'h005A);
        chk("R5 half lo", beat_d[1], 32'h0034);
        chk("R5 half hi", beat_d[2], 32'h0012);
        chk("R2 recovery 3", gap[2], 3);
        end_xfer();
        wide_bus = 1; cyc_len = 1;
        push(2'd0, 32'hFFFF_FF77);
        push(2'd1, 32'hFFFF_ABCD);
        begin_xfer();
        wait_beats(2);
        chk("R4 beat count", nb, 2);
        chk("R5 byte zero fill", beat_d[0], 32'h0077);
        chk("R5 half wide", beat_d[1], 32'hABCD);
        end_xfer();
    endtask

    // queue back-pressure, then drain 18 beats
    task automatic t_full_queue;
        wide_bus = 1; reorder_en = 0; div_sel = 0; wr_act = 0; wr_rec = 2; cyc_len = 17;
        for (int i = 0; i < 8; i++) begin
            tx_push  = 1'b1;
            tx_size  = 2'd2;
            tx_wdata = {8'(i), 8'hA0, 8'(i), 8'h50};
            @(negedge clk);
        end
        tx_push = 1'b0;
        chk("R10 ready after 8", {31'h0, tx_ready}, 32'h1);
        tx_push = 1'b1; tx_wdata = {8'd8, 8'hA0, 8'd8, 8'h50};
        @(negedge clk);
        tx_push = 1'b0;
        chk("R10 full after 9", {31'h0, tx_ready}, 32'h0);
        tx_push = 1'b1; tx_wdata = 32'hBAD0_BAD0;
        @(negedge clk);
        tx_push = 1'b0;
        begin_xfer();
        wait_beats(18);
        chk("R4 R10 beat count", nb, 18);
        for (int i = 0; i < 9; i++) begin
            chk("R10 lo beat", beat_d[2*i], {16'h0, 8'(i), 8'h50});
            chk("R10 hi beat", beat_d[2*i+1], {16'h0, 8'(i), 8'hA0});
        end
        chk("R9 drained after full", {31'h0, wr_drained}, 32'h1);
        end_xfer();
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        for (int k = 0; k < 100 && !rx_valid; k++) @(negedge clk);
        chk(req, rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_read;
        rd_mode = 1; wide_bus = 1; reorder_en = 0; div_sel = 0; rd_act = 1; rd_rec = 3;
        wr_act = 7; wr_rec = 20; cyc_len = 2;
        rd_vals[0] = 16'hAAAA; rd_vals[1] = 16'hBBBB; rd_vals[2] = 16'hCCCC;
        begin_xfer();
        @(negedge clk);
        chk("R11 bus_oe off on read", {31'h0, bus_oe}, 32'h0);
        for (int k = 0; k < 2000 && rd_i < 3; k++) @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R11 read strobes", rd_i, 3);
        chk("R1 R11 read low width", rd_w, 2);
        chk("R11 no write strobe", nb, 0);
        pop_chk("R11 word0", 32'hBBBB_AAAA);
        pop_chk("R11 partial word", 32'h0000_CCCC);
        end_xfer();
        wide_bus = 0; reorder_en = 1; cyc_len = 1;
        rd_vals[0] = 16'h0011; rd_vals[1] = 16'h0022;
        begin_xfer();
        for (int k = 0; k < 2000 && rd_i < 2; k++) @(negedge clk);
        repeat (30) @(negedge clk);
        pop_chk("R6 R11 reordered read", 32'h1122_0000);
        chk("R11 rx empty", {31'h0, rx_valid}, 32'h0);
        end_xfer();
        rd_mode = 0;
    endtask

    // length limit leaves the rest queued
    task automatic t_len_limit;
        wide_bus = 0; reorder_en = 0; div_sel = 1; wr_act = 0; wr_rec = 2; cyc_len = 1;
        push(2'd2, 32'h4433_2211);
        begin_xfer();
        wait_beats(2);
        chk("R4 stops at length", nb, 2);
        chk("R4 beat0", beat_d[0], 32'h0011);
        chk("R4 beat1", beat_d[1], 32'h0022);
        chk("R9 not drained", {31'h0, wr_drained}, 32'h0);
        end_xfer();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_write();
        t_narrow_reorder();
        t_mixed_sizes();
        t_full_queue();
        t_read();
        t_len_limit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule